// File: doc/BRIEF.md
# Synchronous FIFO with Selectable Read Timing

This block is a single-clock first-in first-out buffer. A build-time parameter fixes how its read side behaves. In registered (standard) timing, the consumer raises `rd_en`. The requested word then arrives on `rd_data` one clock later, together with a one-cycle `rd_valid` strobe. In look-ahead (fall-through) timing, the oldest stored word is already on `rd_data` whenever `rd_valid` is high. Raising `rd_en` in that cycle consumes it, so the read itself costs no cycle of latency.

The storage array has no reset, so it can map onto an on-chip RAM with a registered read port. The read and write pointers, the occupancy level and the event pulses are cleared by an active-high synchronous reset. A write into a full buffer or a read from an empty one is dropped, and a one-cycle pulse reports it.

Top module: `fifo_rdmode`

## Requirements
- R1: Registered timing: a read accepted at a clock edge (`rd_en` high while `empty` is low) drives the oldest stored word onto `rd_data` and raises `rd_valid`, both seen after the next edge. Words leave in the order they were written.
- R2: Registered timing: in a cycle with no accepted read, `rd_valid` is low after the edge and `rd_data` keeps the last word it returned.
- R3: Look-ahead timing: `rd_valid` is high exactly when the level is non-zero. While it is high, `rd_data` carries the oldest stored word in the same cycle that `rd_en` is raised to consume it.
- R4: Look-ahead timing: a word written into an empty buffer is on `rd_data` with `rd_valid` high right after the write edge, with no `rd_en` needed.
- R5: Look-ahead timing: with one word stored, a write and a read at the same edge leave `rd_valid` high and show the new word as head after that edge.
- R6: A write while `full` is high is dropped: level and contents are unchanged, and `overflow` pulses high for one cycle after that edge.
- R7: A read while `empty` is high is dropped: level and read order are unchanged, and `underflow` pulses high for one cycle after that edge.
- R8: An accepted write and an accepted read at the same edge leave `level` unchanged.
- R9: `level` gives the number of stored words, from 0 to 2^ADDR_W. `full` is high when the level equals 2^ADDR_W, and `empty` is high when it is 0. All three change the cycle after the edge that pushes or pops.
- R10: After reset, `level` is 0, `empty` is 1, `full`, `rd_valid`, `overflow` and `underflow` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free slot |
| rd_en | input | 1 | Read request (look-ahead: consume head) |
| rd_data | output | DATA_W | Returned word / current head |
| rd_valid | output | 1 | Registered: strobe one cycle after a read; look-ahead: head present |
| empty | output | 1 | No stored word |
| level | output | ADDR_W+1 | Current occupancy |
| overflow | output | 1 | Pulse after a dropped write |
| underflow | output | 1 | Pulse after a dropped read |

## Verification
The hardest case to reach is in look-ahead timing. It happens when the write slot equals the slot the RAM is reading for the next head. That takes an empty buffer being written, or a one-word buffer that is written and read at the same edge, and it is where a stale RAM word would show up. The bench resets the buffer, preloads every level from 0 to full, and then applies all 256 four-cycle sequences of write/read pairs. Every level therefore meets every transition, including these collisions, dropped writes and dropped reads. Both timing variants get the same stimulus and are compared against one arithmetic queue model.

// File: rtl/fifo_rdmode_pkg.sv
package fifo_rdmode_pkg;
  typedef enum logic {
    RD_REGISTERED = 1'b0,
    RD_LOOKAHEAD  = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/fifo_rdmode_ptrs.sv
module fifo_rdmode_ptrs #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              push,
  output logic              pop,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W:0]   level,
  output logic              overflow,
  output logic              underflow
);
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  // wrap bit distinguishes full from empty when addresses match
  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[ADDR_W] != rd_ptr[ADDR_W]) &&
                   (wr_ptr[ADDR_W-1:0] == rd_ptr[ADDR_W-1:0]);
  assign push    = wr_en && !full;
  assign pop     = rd_en && !empty;
  assign wr_addr = wr_ptr[ADDR_W-1:0];
  assign rd_addr = rd_ptr[ADDR_W-1:0];
  assign level   = wr_ptr - rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      overflow  <= wr_en && full;
      underflow <= rd_en && empty;
    end
  end
endmodule

// File: rtl/fifo_rdmode_ram.sv
module fifo_rdmode_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // no reset on array or read register: RAM-inferable
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/fifo_rdmode_fwft_out.sv
module fifo_rdmode_fwft_out #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] head_addr_nxt,
  input  logic [DATA_W-1:0] ram_q,
  input  logic              empty,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              byp_sel;
  logic [DATA_W-1:0] byp_word;

  // RAM reads old contents on a same-edge collision; forward the new word
  always_ff @(posedge clk) begin
    if (rst) byp_sel <= 1'b0;
    else     byp_sel <= push && (wr_addr == head_addr_nxt);
    byp_word <= wr_data;
  end

  assign rd_data  = byp_sel ? byp_word : ram_q;
  assign rd_valid = !empty;
endmodule

// File: rtl/fifo_rdmode.sv
module fifo_rdmode #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter fifo_rdmode_pkg::rd_mode_e RD_MODE = fifo_rdmode_pkg::RD_REGISTERED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty,
  output logic [ADDR_W:0]   level,
  output logic              overflow,
  output logic              underflow
);
  logic              push;
  logic              pop;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic              ram_re;
  logic [ADDR_W-1:0] ram_raddr;
  logic [DATA_W-1:0] ram_q;

  fifo_rdmode_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .push(push), .pop(pop), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .full(full), .empty(empty), .level(level),
    .overflow(overflow), .underflow(underflow)
  );

  fifo_rdmode_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(push), .waddr(wr_addr), .wdata(wr_data),
    .re(ram_re), .raddr(ram_raddr), .q(ram_q)
  );

  generate
    if (RD_MODE == fifo_rdmode_pkg::RD_LOOKAHEAD) begin : g_lookahead
      // prefetch the slot that is head after this edge
      assign ram_re    = 1'b1;
      assign ram_raddr = rd_addr + {{(ADDR_W-1){1'b0}}, pop};

      fifo_rdmode_fwft_out #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_out (
        .clk(clk), .rst(rst), .push(push), .wr_addr(wr_addr),
        .wr_data(wr_data), .head_addr_nxt(ram_raddr), .ram_q(ram_q),
        .empty(empty), .rd_data(rd_data), .rd_valid(rd_valid)
      );
    end else begin : g_registered
      logic strobe_q;

      assign ram_re    = pop;
      assign ram_raddr = rd_addr;
      assign rd_data   = ram_q;
      assign rd_valid  = strobe_q;

      always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= pop;
      end
    end
  endgenerate
endmodule

// File: rtl/fifo_rdmode_chk.sv
module fifo_rdmode_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter fifo_rdmode_pkg::rd_mode_e RD_MODE = fifo_rdmode_pkg::RD_REGISTERED
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              full,
  input logic              empty,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W:0]   level,
  input logic              overflow,
  input logic              underflow
);
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (overflow && $stable(level)));

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en) |=> (underflow && $stable(level)));

  assert_level_steady_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !full && !empty) |=> $stable(level));

  generate
    if (RD_MODE == fifo_rdmode_pkg::RD_LOOKAHEAD) begin : g_la
      assert_valid_level_R3: assert property (@(posedge clk) disable iff (rst)
        rd_valid == (level != '0));
      assert_head_steady_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_en) |=> $stable(rd_data));
      assert_first_word_R4: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_en) |=> rd_valid);
    end else begin : g_reg
      assert_read_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty) |=> rd_valid);
      assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && !empty) |=> (!rd_valid && $stable(rd_data)));
    end
  endgenerate
endmodule

bind fifo_rdmode fifo_rdmode_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_MODE(RD_MODE)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .full(full),
  .empty(empty), .rd_valid(rd_valid), .rd_data(rd_data), .level(level),
  .overflow(overflow), .underflow(underflow)
);

// File: tb/test_fifo_rdmode.sv
module test_fifo_rdmode;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;

  logic s_full, s_empty, s_valid, s_ovf, s_unf;
  logic [DW-1:0] s_data;
  logic [AW:0] s_level;
  logic f_full, f_empty, f_valid, f_ovf, f_unf;
  logic [DW-1:0] f_data;
  logic [AW:0] f_level;

  always #5 clk = ~clk;

  fifo_rdmode #(.DATA_W(DW), .ADDR_W(AW),
    .RD_MODE(fifo_rdmode_pkg::RD_REGISTERED)) i_fifo_rdmode (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(s_full),
    .rd_en(rd_en), .rd_data(s_data), .rd_valid(s_valid), .empty(s_empty),
    .level(s_level), .overflow(s_ovf), .underflow(s_unf));

  fifo_rdmode #(.DATA_W(DW), .ADDR_W(AW),
    .RD_MODE(fifo_rdmode_pkg::RD_LOOKAHEAD)) i_fifo_rdmode_la (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(f_full),
    .rd_en(rd_en), .rd_data(f_data), .rd_valid(f_valid), .empty(f_empty),
    .level(f_level), .overflow(f_ovf), .underflow(f_unf));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [DW-1:0] mq [D];
  int hd, cnt;
  logic [DW-1:0] exp_sd;
  bit sd_known, exp_sv, exp_ovf, exp_unf;
  logic [DW-1:0] seq_word = 8'd1;

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_flags(string lreq);
    check(lreq, "reg level", int'(s_level), cnt);
    check(lreq, "la level", int'(f_level), cnt);
    check("R9", "reg full", int'(s_full), int'(cnt == D));
    check("R9", "reg empty", int'(s_empty), int'(cnt == 0));
    check("R9", "la full", int'(f_full), int'(cnt == D));
    check("R9", "la empty", int'(f_empty), int'(cnt == 0));
    check("R6", "reg overflow", int'(s_ovf), int'(exp_ovf));
    check("R6", "la overflow", int'(f_ovf), int'(exp_ovf));
    check("R7", "reg underflow", int'(s_unf), int'(exp_unf));
    check("R7", "la underflow", int'(f_unf), int'(exp_unf));
  endtask

  task automatic check_head(string req);
    check(req, "la valid", int'(f_valid), int'(cnt > 0));
    if (cnt > 0) check(req, "la head", int'(f_data), int'(mq[hd]));
  endtask

  task automatic step(bit we, bit re);
    int prev;
    bit push, pop;
    string htag, ltag;
    @(negedge clk);
    wr_en = we; rd_en = re; wr_data = seq_word; seq_word = seq_word + 8'd1;
    #1 check_head("R3");   // head present in the cycle rd_en is raised
    @(posedge clk);
    prev = cnt;
    push = we && (cnt < D);
    pop  = re && (cnt > 0);
    exp_ovf = we && (cnt == D);
    exp_unf = re && (cnt == 0);
    exp_sv  = pop;
    if (pop) begin
      exp_sd = mq[hd]; sd_known = 1;
      hd = (hd + 1) % D; cnt--;
    end
    if (push) begin
      mq[(hd + cnt) % D] = wr_data; cnt++;
    end
    htag = "R3";
    if (prev == 0 && push) htag = "R4";
    if (prev == 1 && push && pop) htag = "R5";
    ltag = (push && pop) ? "R8" : "R9";
    #2;
    check_flags(ltag);
    check_head(htag);
    check(pop ? "R1" : "R2", "reg valid", int'(s_valid), int'(exp_sv));
    if (pop) check("R1", "reg data", int'(s_data), int'(exp_sd));
    else if (sd_known) check("R2", "reg data hold", int'(s_data), int'(exp_sd));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_en = 0; rd_en = 0;
    @(posedge clk);
    @(posedge clk);
    #2;
    cnt = 0; hd = 0; sd_known = 0; exp_sv = 0; exp_ovf = 0; exp_unf = 0;
    check("R10", "reg level", int'(s_level), 0);
    check("R10", "la level", int'(f_level), 0);
    check("R10", "reg empty", int'(s_empty), 1);
    check("R10", "la empty", int'(f_empty), 1);
    check("R10", "reg full", int'(s_full), 0);
    check("R10", "la full", int'(f_full), 0);
    check("R10", "reg valid", int'(s_valid), 0);
    check("R10", "la valid", int'(f_valid), 0);
    check("R10", "overflow", int'(s_ovf | f_ovf), 0);
    check("R10", "underflow", int'(s_unf | f_unf), 0);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    for (int lvl = 0; lvl <= D; lvl++) begin
      do_reset();
      for (int k = 0; k < lvl; k++) step(1'b1, 1'b0);
      for (int pat = 0; pat < 256; pat++) begin
        for (int k = 0; k < 4; k++) begin
          step(pat[2*k+1], pat[2*k]);
        end
      end
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule